// File: doc/BRIEF.md
# Clock Stop and Power-Down Gate

This block sits between a clock source and a set of clock output drivers. It takes a processor-side clock and a bus-side clock and produces several identical gated copies of each, plus one bus-side copy that keeps running when the bus copies are stopped. Three active-low control inputs can silence the outputs. A processor-stop request parks the processor copies. A bus-stop request parks the gated bus copies. A power-down request parks everything and reports a status flag.

Every control input is asynchronous. Each one passes through a two-stage synchronizer in the clock domain it governs, and the gating enable changes only while that clock is low. An output therefore always stops in the low state after a whole high phase and starts again with a whole high phase. It never produces a shortened pulse. When power-down is released, the outputs stay low for a programmable number of processor cycles. This stands in for the time the frequency synthesizer needs to settle. Power-down overrides both stop requests. A stop request raised during power-down still applies once the block wakes.

Top module: `clk_stop_ctrl`

## Requirements
- R1: When `cpu_stop_n` falls in the low phase of `cpu_clk`, every `cpu_clk_o` copy gives exactly two more complete high phases and then stays low. If the fall comes at an arbitrary time, three high phases may follow instead.
- R2: When `cpu_stop_n` returns high in the low phase of `cpu_clk` and power-down is inactive, the `cpu_clk_o` copies resume at the third rising edge of `cpu_clk` that follows. The first pulse they give is a complete high phase.
- R3: Every gated output is low throughout the low phase of its source clock. Its high phases are either whole or absent. All copies within a group carry the same value.
- R4: `pci_stop_n` is sampled on rising edges of `pci_clk`. When it falls in the low phase, every `pci_clk_o` copy gives two more complete high phases and then stays at logic 0.
- R5: While `pci_stop_n` is high and power-down is inactive, the `pci_clk_o` copies follow `pci_clk`. After a release in the low phase, they resume at the third rising edge.
- R6: `pci_free_o` follows `pci_clk` whatever the level of `pci_stop_n`. Only power-down stops it.
- R7: When `pwrdn_n` falls in the low phase of `cpu_clk`, the `cpu_clk_o` copies give two more complete high phases and then stay low. `pwrdn_active` rises in the same cycle in which the last of those pulses starts. Once the request has crossed into the bus domain, `pci_clk_o` and `pci_free_o` are also held low.
- R8: When `pwrdn_n` is released in the low phase of `cpu_clk`, the first `cpu_clk_o` pulse comes at rising edge WAKE_CYCLES+4 after the release, and `pwrdn_active` falls one cycle before it. If power-down is requested again during this wait, the wait starts over on the next release.
- R9: Power-down takes priority over both stop inputs. A stop input that is low when the wake-up wait ends keeps its group low after wake-up, and the group resumes only when that stop input returns high.
- R10: While `rst_n` is low across rising edges of both clocks, every clock output is low and `pwrdn_active` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| cpu_clk | input | 1 | Processor-side source clock |
| pci_clk | input | 1 | Bus-side source clock |
| rst_n | input | 1 | Active-low reset, sampled synchronously in each domain |
| cpu_stop_n | input | 1 | Asynchronous request to park the processor copies, active low |
| pci_stop_n | input | 1 | Asynchronous request to park the gated bus copies, active low |
| pwrdn_n | input | 1 | Asynchronous power-down request, active low |
| cpu_clk_o | output | N_CPU | Gated processor clock copies |
| pci_clk_o | output | N_PCI | Gated bus clock copies |
| pci_free_o | output | 1 | Bus clock copy that stop requests do not affect |
| pwrdn_active | output | 1 | High while powered down or waiting to wake |

## Verification
The bench drives one-cycle stop pulses to check the rule that a pulse is either whole or missing. A design that gated on the rising edge, or that skipped the synchronizer, would show a slipped or clipped pulse at the high-phase sample. It counts the exact edge of the first pulse after a wake-up, including a power-down that is re-requested partway through the wait. An off-by-one counter, or a wait that does not restart, moves that edge. It raises both stop inputs during power-down and checks that the groups stay parked after wake-up while the free bus copy restarts. A design that let power-down clear pending stops, or that gated the free copy with bus stop, fails that check.

// File: rtl/clk_stop_pkg.sv
// Shared types for the clock stop and power-down gate.
// Assumes: one package, imported by the power sequencer.
package clk_stop_pkg;

    // Power sequencer states: running, held down, counting toward wake-up.
    typedef enum logic [1:0] {
        PWR_RUN  = 2'd0,
        PWR_DOWN = 2'd1,
        PWR_WAKE = 2'd2
    } pwr_state_e;

endpackage

// File: rtl/cg_sync2.sv
// Two-stage synchronizer for one asynchronous level.
// Assumes: the input is a quasi-static control level. Reset is synchronous and
// active low, and it loads RST_VAL into both stages.
module cg_sync2 #(
    parameter logic RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);

    logic stage1;

    // Shift the input through two flops in the destination domain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage1 <= RST_VAL;
            q      <= RST_VAL;
        end else begin
            stage1 <= d;
            q      <= stage1;
        end
    end

endmodule

// File: rtl/cg_gate_cell.sv
// Glitch-free clock gates: one enable flop per output copy, updated on the
// falling edge and ANDed with the source clock.
// Assumes: en is synchronous to clk and changes only after rising edges.
module cg_gate_cell #(
    parameter int WIDTH = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    output logic [WIDTH-1:0] clk_o
);

    for (genvar g = 0; g < WIDTH; g++) begin : g_copy
        logic en_q;

        // Load the enable while clk is low so a high phase is never cut.
        always_ff @(negedge clk) begin
            if (!rst_n) begin
                en_q <= 1'b0;
            end else begin
                en_q <= en;
            end
        end

        assign clk_o[g] = clk & en_q;
    end

endmodule

// File: rtl/cg_pwr_seq.sv
// Power sequencer: it follows the synchronized power-down request and keeps
// the clocks off for WAKE_CYCLES cycles after each release.
// Assumes: pd_ok is already synchronized (1 = run). WAKE_CYCLES >= 1.
module cg_pwr_seq
    import clk_stop_pkg::*;
#(
    parameter int WAKE_CYCLES = 150000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pd_ok,
    output logic run_ok
);

    localparam int CW = (WAKE_CYCLES > 1) ? $clog2(WAKE_CYCLES) : 1;

    pwr_state_e    state;
    logic [CW-1:0] wait_cnt;

    // Track the down, wake and run phases and count the wake-up wait.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= PWR_RUN;
            wait_cnt <= '0;
        end else begin
            unique case (state)
                PWR_RUN: begin
                    if (!pd_ok) state <= PWR_DOWN;
                end
                PWR_DOWN: begin
                    if (pd_ok) begin
                        state    <= PWR_WAKE;
                        wait_cnt <= CW'(WAKE_CYCLES - 1);
                    end
                end
                PWR_WAKE: begin
                    if (!pd_ok)               state    <= PWR_DOWN;
                    else if (wait_cnt == '0)  state    <= PWR_RUN;
                    else                      wait_cnt <= wait_cnt - 1'b1;
                end
                default: state <= PWR_RUN;
            endcase
        end
    end

    // Clocks run only in the run state while the request stays released.
    assign run_ok = (state == PWR_RUN) && pd_ok;

endmodule

// File: rtl/clk_stop_ctrl.sv
// Clock stop and power-down gate. It drives N_CPU gated processor copies,
// N_PCI gated bus copies and one bus copy that ignores bus stop.
// Assumes: control inputs are asynchronous levels. rst_n is held low across
// at least two rising and two falling edges of each clock.
module clk_stop_ctrl #(
    parameter int N_CPU       = 6,
    parameter int N_PCI       = 7,
    parameter int WAKE_CYCLES = 150000
) (
    input  logic             cpu_clk,
    input  logic             pci_clk,
    input  logic             rst_n,
    input  logic             cpu_stop_n,
    input  logic             pci_stop_n,
    input  logic             pwrdn_n,
    output logic [N_CPU-1:0] cpu_clk_o,
    output logic [N_PCI-1:0] pci_clk_o,
    output logic             pci_free_o,
    output logic             pwrdn_active
);

    logic cpu_stop_s;
    logic pd_ok_s;
    logic run_ok;
    logic cpu_en;
    logic pci_stop_s;
    logic pci_run_s;
    logic pci_en;
    logic [0:0] free_vec;

    // Processor domain: synchronize the stop and power-down requests.
    cg_sync2 #(.RST_VAL(1'b1)) u_sync_cstop (
        .clk(cpu_clk), .rst_n(rst_n), .d(cpu_stop_n), .q(cpu_stop_s)
    );
    cg_sync2 #(.RST_VAL(1'b1)) u_sync_pd (
        .clk(cpu_clk), .rst_n(rst_n), .d(pwrdn_n), .q(pd_ok_s)
    );

    cg_pwr_seq #(.WAKE_CYCLES(WAKE_CYCLES)) u_pwr (
        .clk(cpu_clk), .rst_n(rst_n), .pd_ok(pd_ok_s), .run_ok(run_ok)
    );

    assign cpu_en       = run_ok & cpu_stop_s;
    assign pwrdn_active = ~run_ok;

    cg_gate_cell #(.WIDTH(N_CPU)) u_cpu_gate (
        .clk(cpu_clk), .rst_n(rst_n), .en(cpu_en), .clk_o(cpu_clk_o)
    );

    // Bus domain: synchronize bus stop and carry the run permission across.
    cg_sync2 #(.RST_VAL(1'b1)) u_sync_pstop (
        .clk(pci_clk), .rst_n(rst_n), .d(pci_stop_n), .q(pci_stop_s)
    );
    cg_sync2 #(.RST_VAL(1'b1)) u_sync_run (
        .clk(pci_clk), .rst_n(rst_n), .d(run_ok), .q(pci_run_s)
    );

    assign pci_en = pci_run_s & pci_stop_s;

    cg_gate_cell #(.WIDTH(N_PCI)) u_pci_gate (
        .clk(pci_clk), .rst_n(rst_n), .en(pci_en), .clk_o(pci_clk_o)
    );
    cg_gate_cell #(.WIDTH(1)) u_free_gate (
        .clk(pci_clk), .rst_n(rst_n), .en(pci_run_s), .clk_o(free_vec)
    );

    assign pci_free_o = free_vec[0];

endmodule

// File: rtl/clk_stop_ctrl_chk.sv
// Property checker for clk_stop_ctrl, bound to every instance.
// Assumes: sampling on the falling edge shows the value an output held
// during the high phase that just ended.
module clk_stop_ctrl_chk #(
    parameter int N_CPU = 6,
    parameter int N_PCI = 7
) (
    input logic             cpu_clk,
    input logic             pci_clk,
    input logic             rst_n,
    input logic             cpu_stop_n,
    input logic             pci_stop_n,
    input logic             pwrdn_n,
    input logic [N_CPU-1:0] cpu_clk_o,
    input logic [N_PCI-1:0] pci_clk_o,
    input logic             pci_free_o,
    input logic             pwrdn_active
);

    logic [2:0] cpu_warm;
    logic [2:0] pci_warm;

    // Count falling edges since reset so that $past never reaches before it.
    always_ff @(negedge cpu_clk) begin
        if (!rst_n)              cpu_warm <= '0;
        else if (cpu_warm != 3'd7) cpu_warm <= cpu_warm + 1'b1;
    end

    // Same warm-up count for the bus domain.
    always_ff @(negedge pci_clk) begin
        if (!rst_n)              pci_warm <= '0;
        else if (pci_warm != 3'd7) pci_warm <= pci_warm + 1'b1;
    end

    // R1: a stop held for three samples leaves the processor copies low
    a_r1_cpu_parked: assert property (@(negedge cpu_clk) disable iff (!rst_n)
        (cpu_warm >= 3'd4 && !$past(cpu_stop_n, 3) && !$past(cpu_stop_n, 2) && !$past(cpu_stop_n, 1))
        |-> (cpu_clk_o == '0));

    // R2: released stop and no power-down give a full pulse on every copy
    a_r2_cpu_running: assert property (@(negedge cpu_clk) disable iff (!rst_n)
        (cpu_warm >= 3'd4 && $past(cpu_stop_n, 3) && $past(cpu_stop_n, 2) && $past(cpu_stop_n, 1)
         && !$past(pwrdn_active))
        |-> (cpu_clk_o == '1));

    // R3: copies agree and nothing is high while the source clock is low
    a_r3_cpu_copies_agree: assert property (@(negedge cpu_clk) disable iff (!rst_n)
        (cpu_clk_o == '0) || (cpu_clk_o == '1));
    a_r3_cpu_low_phase: assert property (@(posedge cpu_clk) disable iff (!rst_n)
        (cpu_warm >= 3'd1) |-> (cpu_clk_o == '0));
    a_r3_pci_copies_agree: assert property (@(negedge pci_clk) disable iff (!rst_n)
        (pci_warm >= 3'd1) |-> ((pci_clk_o == '0) || (pci_clk_o == '1)));

    // R4: a bus stop held for three samples leaves the gated bus copies low
    a_r4_pci_parked: assert property (@(negedge pci_clk) disable iff (!rst_n)
        (pci_warm >= 3'd4 && !$past(pci_stop_n, 3) && !$past(pci_stop_n, 2) && !$past(pci_stop_n, 1))
        |-> (pci_clk_o == '0));

    // R6: a gated bus pulse never appears without the free copy
    a_r6_free_covers_gated: assert property (@(negedge pci_clk) disable iff (!rst_n)
        (pci_warm >= 3'd1 && pci_clk_o != '0) |-> pci_free_o);

    // R7: a held power-down raises the flag, and the flag keeps the processor copies low
    a_r7_pd_flag: assert property (@(negedge cpu_clk) disable iff (!rst_n)
        (cpu_warm >= 3'd4 && !$past(pwrdn_n, 3) && !$past(pwrdn_n, 2) && !$past(pwrdn_n, 1))
        |-> pwrdn_active);
    a_r7_pd_cpu_low: assert property (@(negedge cpu_clk) disable iff (!rst_n)
        (cpu_warm >= 3'd2 && $past(pwrdn_active)) |-> (cpu_clk_o == '0));

endmodule

bind clk_stop_ctrl clk_stop_ctrl_chk #(.N_CPU(N_CPU), .N_PCI(N_PCI)) chk_i (
    .cpu_clk(cpu_clk), .pci_clk(pci_clk), .rst_n(rst_n),
    .cpu_stop_n(cpu_stop_n), .pci_stop_n(pci_stop_n), .pwrdn_n(pwrdn_n),
    .cpu_clk_o(cpu_clk_o), .pci_clk_o(pci_clk_o), .pci_free_o(pci_free_o),
    .pwrdn_active(pwrdn_active)
);

// File: tb/clk_stop_ctrl_tb_top.sv
// Scoreboard bench: each domain has a driver that applies the commands at
// falling edges and queues the expected high phase for the next rising edge.
// A monitor pops the queue and compares at mid-high and mid-low.
module clk_stop_ctrl_tb_top;

    localparam int N_CPU = 6;
    localparam int N_PCI = 7;
    localparam int WAKE  = 8;

    logic cpu_clk = 1'b0;
    logic pci_clk = 1'b0;
    logic rst_n = 1'b0;
    logic cpu_stop_n = 1'b1;
    logic pci_stop_n = 1'b1;
    logic pwrdn_n = 1'b1;
    logic [N_CPU-1:0] cpu_clk_o;
    logic [N_PCI-1:0] pci_clk_o;
    logic pci_free_o;
    logic pwrdn_active;

    always #10 cpu_clk = ~cpu_clk;
    always #30 pci_clk = ~pci_clk;

    clk_stop_ctrl #(.N_CPU(N_CPU), .N_PCI(N_PCI), .WAKE_CYCLES(WAKE)) dut_i (
        .cpu_clk(cpu_clk), .pci_clk(pci_clk), .rst_n(rst_n),
        .cpu_stop_n(cpu_stop_n), .pci_stop_n(pci_stop_n), .pwrdn_n(pwrdn_n),
        .cpu_clk_o(cpu_clk_o), .pci_clk_o(pci_clk_o), .pci_free_o(pci_free_o),
        .pwrdn_active(pwrdn_active)
    );

    typedef struct packed { logic pulse; logic ok; } cpu_item_t;

    int n_checks = 0;
    int n_fail   = 0;
    bit cmd_cpu_stop = 1'b1;
    bit cmd_pci_stop = 1'b1;
    bit cmd_pd = 1'b1;
    bit cpu_track = 1'b0;
    bit pci_track = 1'b0;
    cpu_item_t cq[$];
    bit pq[$];

    task automatic chk(input bit cond, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!cond) begin
            n_fail++;
            $display("FAIL %s at %0t: actual %0h expected %0h", req, $time, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    endtask

    // Processor driver: apply commands at falling edges; expected pulse is the
    // stop level from two edges back, gated by the power window (R1 R2 R7 R8 R9).
    initial begin : cpu_drv
        bit c1, c2, cur_ok;
        int rl1, rl2, rl_cur;
        c1 = 1'b1; c2 = 1'b1; rl1 = 1000; rl2 = 1000;
        forever begin
            @(negedge cpu_clk);
            cur_ok = (rl2 >= WAKE + 2);
            if (cpu_track) cq.push_back('{pulse: c2 && cur_ok, ok: cur_ok});
            cpu_stop_n = cmd_cpu_stop;
            pwrdn_n    = cmd_pd;
            rl_cur = cmd_pd ? ((rl1 >= 1000) ? 1000 : rl1 + 1) : 0;
            c2 = c1; c1 = cmd_cpu_stop;
            rl2 = rl1; rl1 = rl_cur;
        end
    end

    // Processor monitor: compare the high phase, the flag and the low phase.
    initial begin : cpu_mon
        cpu_item_t it;
        bit have_prev, prev_flag;
        have_prev = 1'b0;
        prev_flag = 1'b0;
        forever begin
            @(posedge cpu_clk);
            #5;
            if (cq.size() > 0) begin
                it = cq.pop_front();
                chk(cpu_clk_o == (it.pulse ? {N_CPU{1'b1}} : {N_CPU{1'b0}}),
                    "R1/R2/R7/R8/R9 cpu high phase", 32'(cpu_clk_o),
                    it.pulse ? 32'({N_CPU{1'b1}}) : 32'd0);
                if (have_prev)
                    chk(prev_flag == !it.ok, "R7/R8 pwrdn_active", 32'(prev_flag), 32'(!it.ok));
                prev_flag = pwrdn_active;
                have_prev = 1'b1;
                #10;
                chk(cpu_clk_o == '0, "R3 cpu low phase", 32'(cpu_clk_o), 32'd0);
            end else begin
                have_prev = 1'b0;
            end
        end
    end

    // Bus driver: expected gated pulse is the bus stop level from two edges back (R4 R5).
    initial begin : pci_drv
        bit p1, p2;
        p1 = 1'b1; p2 = 1'b1;
        forever begin
            @(negedge pci_clk);
            if (pci_track) pq.push_back(p2);
            pci_stop_n = cmd_pci_stop;
            p2 = p1; p1 = cmd_pci_stop;
        end
    end

    // Bus monitor: gated copies, free copy (R6) and low phase (R3).
    initial begin : pci_mon
        bit e;
        forever begin
            @(posedge pci_clk);
            #15;
            if (pq.size() > 0) begin
                e = pq.pop_front();
                chk(pci_clk_o == (e ? {N_PCI{1'b1}} : {N_PCI{1'b0}}), "R4/R5 pci high phase",
                    32'(pci_clk_o), e ? 32'({N_PCI{1'b1}}) : 32'd0);
                chk(pci_free_o == 1'b1, "R6 free copy running", 32'(pci_free_o), 32'd1);
                #30;
                chk(pci_clk_o == '0 && pci_free_o == 1'b0, "R3 pci low phase",
                    32'({pci_free_o, pci_clk_o}), 32'd0);
            end
        end
    end

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        #(20 * 150000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog at %0t: actual running expected finished", $time);
        finish_run();
    end

    task automatic cpu_cycles(input int n);
        repeat (n) @(posedge cpu_clk);
        #1;
    endtask

    task automatic pci_cycles(input int n);
        repeat (n) @(posedge pci_clk);
        #1;
    endtask

    task automatic pci_probe(input logic [N_PCI-1:0] exp_g, input logic exp_f, input string req);
        @(posedge pci_clk);
        #15;
        chk(pci_clk_o == exp_g, req, 32'(pci_clk_o), 32'(exp_g));
        chk(pci_free_o == exp_f, req, 32'(pci_free_o), 32'(exp_f));
    endtask

    initial begin
        // R10: reset state, probed late in reset once both domains have had edges.
        repeat (11) @(posedge cpu_clk);
        #5;
        chk(cpu_clk_o == '0, "R10 reset cpu outputs", 32'(cpu_clk_o), 32'd0);
        chk(pci_clk_o == '0 && pci_free_o == 1'b0, "R10 reset pci outputs",
            32'({pci_free_o, pci_clk_o}), 32'd0);
        chk(pwrdn_active == 1'b0, "R10 reset flag", 32'(pwrdn_active), 32'd0);
        @(posedge cpu_clk);
        #1 rst_n = 1'b1;
        cpu_cycles(10);
        cpu_track = 1'b1;
        cpu_cycles(6);

        // R1 and R2: long processor stop, then release.
        cmd_cpu_stop = 1'b0;
        cpu_cycles(10);
        cmd_cpu_stop = 1'b1;
        cpu_cycles(8);

        // R3: one-cycle stop pulse removes exactly one whole pulse.
        cmd_cpu_stop = 1'b0;
        cpu_cycles(1);
        cmd_cpu_stop = 1'b1;
        cpu_cycles(8);

        // R4 R5 R6: bus stop, release and one-cycle stop.
        pci_track = 1'b1;
        pci_cycles(4);
        cmd_pci_stop = 1'b0;
        pci_cycles(6);
        cmd_pci_stop = 1'b1;
        pci_cycles(6);
        cmd_pci_stop = 1'b0;
        pci_cycles(1);
        cmd_pci_stop = 1'b1;
        pci_cycles(5);
        pci_track = 1'b0;
        pci_cycles(2);

        // R7: power-down parks every output; R8: wake-up wait.
        cmd_pd = 1'b0;
        cpu_cycles(40);
        pci_probe('0, 1'b0, "R7 pci held low in power-down");
        pci_probe('0, 1'b0, "R7 pci held low in power-down");
        cmd_pd = 1'b1;
        cpu_cycles(40);
        pci_probe('1, 1'b1, "R8 pci running after wake-up");

        // R9: stops raised during power-down still apply after wake-up.
        cmd_pd = 1'b0;
        cpu_cycles(20);
        cmd_cpu_stop = 1'b0;
        cmd_pci_stop = 1'b0;
        cpu_cycles(5);
        cmd_pd = 1'b1;
        cpu_cycles(40);
        pci_probe('0, 1'b1, "R9 pci stop kept after wake-up");
        pci_probe('0, 1'b1, "R9 pci stop kept after wake-up");
        cmd_cpu_stop = 1'b1;
        cmd_pci_stop = 1'b1;
        cpu_cycles(20);
        pci_probe('1, 1'b1, "R9 pci resumes after stop release");

        // R8: power-down re-requested during the wait restarts it.
        cmd_pd = 1'b0;
        cpu_cycles(10);
        cmd_pd = 1'b1;
        cpu_cycles(5);
        cmd_pd = 1'b0;
        cpu_cycles(2);
        cmd_pd = 1'b1;
        cpu_cycles(30);

        cpu_track = 1'b0;
        cpu_cycles(3);
        finish_run();
    end

endmodule